// File: doc/BRIEF.md
# Strobe-Driven Watchdog Timer

This block watches a service strobe from a processor and raises a one-cycle timeout request towards a reset pulse generator when the processor stops servicing it. Service is a high-to-low transition of the strobe, seen after a two-flop synchronizer. A steady strobe, at either level, is treated as a hung processor. Time is measured in ticks of an external time-base enable, so the limits below are tick counts. The timer cannot be switched off: every select code leads to a finite timeout.

The timeout length comes from a 2-bit select standing for a pin that is grounded, floating or tied high. The select is captured only at the moment the system reset status is released. While that status is active, the counter is held at zero. After a request has been issued the block stays quiet until reset has been seen active and then inactive again.

The controller has three states. `ST_HOLD` is the reset-held state. `ST_RUN` is the counting state. `ST_FIRED` is the state after a request. The transitions are:
- HOLD→RUN on release, which also captures the select code.
- RUN→HOLD when reset becomes active.
- RUN→FIRED on expiry with no service, which issues the request.
- FIRED→HOLD when reset becomes active.

Top module: `strobe_watchdog`

## Requirements
- R1: While `rst_n` is low and after it rises, `timeout_req` is 0. The controller starts in ST_HOLD.
- R2: While `rst_active` is 1 the counter is held at zero and `timeout_req` stays 0, however long the strobe is left alone.
- R3: The select codes map to limits as follows: 2'b00 (grounded) gives LIM_GND, 2'b01 (floating) gives LIM_OPEN, 2'b10 (tied high) gives LIM_HIGH, and the spare 2'b11 also gives LIM_HIGH. No code disables the timer.
- R4: Take the rising edge that first samples `rst_active` low as edge 1, with `tick` held at 1 and no service. `timeout_req` is then 1 after edge L+2, where L is the selected limit.
- R5: Let edge 1 be the first rising edge after `strobe` falls. The counter restarts from zero at edge 3, so the request comes after edge 3+L+1.
- R6: A strobe held low, a strobe held high, and a low-to-high strobe transition do not restart the count.
- R7: A falling edge detected in the same cycle that the count reaches L wins over expiry. The count restarts and no request is issued.
- R8: The select code is sampled only on release. A change to `sel` while counting does not alter the running limit.
- R9: `timeout_req` lasts exactly one cycle. After it, no further request occurs, whatever the strobe does, until `rst_active` has been 1 and then 0 again.
- R10: The counter advances only on cycles where `tick` is 1. Counting begins with the first tick after release, and the request comes one edge after the L-th tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base enable, one count per cycle it is high |
| rst_active | input | 1 | System reset status, 1 while reset is asserted |
| strobe | input | 1 | Asynchronous service strobe, falling edge services |
| sel | input | 2 | Period select code (grounded, floating, tied-high, spare) |
| timeout_req | output | 1 | One-cycle request for a system reset |

## Verification
The request is due L+2 rising edges after release: one edge moves the controller into ST_RUN, L edges count, and one more edge registers the request. A strobe fall clears the counter three edges after it is driven, because of the two synchronizer flops and the edge detector. The bench drives inputs one nanosecond after a rising edge and counts edges from the first one that can see the new value. It samples `timeout_req` one nanosecond after each edge and compares the edge index of the first request against those sums. Quiet windows are checked by counting every request over a span longer than the largest limit.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        SEL_GND   = 2'b00,
        SEL_OPEN  = 2'b01,
        SEL_HIGH  = 2'b10,
        SEL_SPARE = 2'b11
    } sel_code_t;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'b00,
        ST_RUN   = 2'b01,
        ST_FIRED = 2'b10
    } wd_state_t;

endpackage

// File: rtl/strobe_edge_det.sv
module strobe_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic fall
);
    localparam int CHAIN = SYNC_STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[CHAIN-2:0], strobe};
        end
    end

    // last synchronized sample was high, newest synchronized sample is low
    assign fall = chain_q[CHAIN-1] & ~chain_q[CHAIN-2];

    // R5
    fall_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/period_latch.sv
module period_latch
    import wdt_pkg::*;
#(
    parameter int CW       = 10,
    parameter int LIM_GND  = 63,
    parameter int LIM_OPEN = 250,
    parameter int LIM_HIGH = 500
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [1:0]    sel,
    output logic [CW-1:0] limit
);
    localparam logic [CW-1:0] L_GND  = CW'(LIM_GND);
    localparam logic [CW-1:0] L_OPEN = CW'(LIM_OPEN);
    localparam logic [CW-1:0] L_HIGH = CW'(LIM_HIGH);

    logic [CW-1:0] decoded;

    always_comb begin
        unique case (sel_code_t'(sel))
            SEL_GND:   decoded = L_GND;
            SEL_OPEN:  decoded = L_OPEN;
            SEL_HIGH:  decoded = L_HIGH;
            SEL_SPARE: decoded = L_HIGH;
            default:   decoded = L_HIGH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            limit <= L_HIGH;
        end else if (load) begin
            limit <= decoded;
        end
    end

    // R3
    limit_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        limit != '0);

endmodule

// File: rtl/expire_counter.sv
module expire_counter #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          expired
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + ONE;
        end
    end

    assign expired = (cnt_q == limit);

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= limit + ONE);

    // R10
    tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !tick) |=> $stable(cnt_q));

endmodule

// File: rtl/strobe_watchdog.sv
module strobe_watchdog
    import wdt_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int LIM_GND     = 63,
    parameter int LIM_OPEN    = 250,
    parameter int LIM_HIGH    = 500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rst_active,
    input  logic       strobe,
    input  logic [1:0] sel,
    output logic       timeout_req
);
    localparam int LIM_A   = (LIM_GND > LIM_OPEN) ? LIM_GND : LIM_OPEN;
    localparam int LIM_MAX = (LIM_A > LIM_HIGH) ? LIM_A : LIM_HIGH;
    localparam int CW      = $clog2(LIM_MAX + 2);

    wd_state_t     state_q, state_d;
    logic          fall;
    logic          expired;
    logic          load;
    logic          clr;
    logic [CW-1:0] limit;

    strobe_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (strobe),
        .fall   (fall)
    );

    period_latch #(
        .CW       (CW),
        .LIM_GND  (LIM_GND),
        .LIM_OPEN (LIM_OPEN),
        .LIM_HIGH (LIM_HIGH)
    ) u_period (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .sel   (sel),
        .limit (limit)
    );

    expire_counter #(.CW(CW)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .tick    (tick),
        .limit   (limit),
        .expired (expired)
    );

    assign load = (state_q == ST_HOLD) && !rst_active;
    assign clr  = (state_q != ST_RUN) || fall;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:  if (!rst_active) state_d = ST_RUN;
            ST_RUN: begin
                if (rst_active)           state_d = ST_HOLD;
                else if (expired && !fall) state_d = ST_FIRED;
            end
            ST_FIRED: if (rst_active)  state_d = ST_HOLD;
            default:                   state_d = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) timeout_req <= 1'b0;
        else        timeout_req <= (state_q == ST_RUN) && (state_d == ST_FIRED);
    end

    // R9
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_req |=> !timeout_req);

    // R2
    req_not_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_req |-> !$past(rst_active));

    // R9
    fired_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIRED && $past(state_q == ST_FIRED)) |-> !timeout_req);

    // R8
    limit_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && $past(state_q == ST_RUN)) |-> $stable(limit));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |-> (state_q == ST_HOLD && !timeout_req));

endmodule

// File: tb/strobe_watchdog_test.sv
`timescale 1ns/1ps
module strobe_watchdog_test;

    localparam int LG = 20;
    localparam int LO = 40;
    localparam int LH = 60;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       rst_active = 1'b1;
    logic       strobe = 1'b1;
    logic [1:0] sel = 2'b00;
    logic       timeout_req;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    strobe_watchdog #(
        .SYNC_STAGES (2),
        .LIM_GND     (LG),
        .LIM_OPEN    (LO),
        .LIM_HIGH    (LH)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .rst_active  (rst_active),
        .strobe      (strobe),
        .sel         (sel),
        .timeout_req (timeout_req)
    );

    // columns: sel at release, sel forced at k=3 (-1 none), expected edge of request
    localparam int NV = 5;
    localparam int VEC [NV][3] = '{
        '{0, -1, LG + 2},   // R3 R4 grounded
        '{1, -1, LO + 2},   // R3 R4 floating
        '{2, -1, LH + 2},   // R3 R4 tied high
        '{3, -1, LH + 2},   // R3 spare code -> longest
        '{0,  2, LG + 2}    // R8 mid-run change ignored
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic prepare(input logic [1:0] s, input logic stb);
        @(negedge clk);
        rst_active = 1'b1;
        sel = s;
        strobe = stb;
        tick = 1'b1;
        repeat (6) @(posedge clk);
    endtask

    task automatic release_wd();
        @(negedge clk);
        rst_active = 1'b0;
    endtask

    // k = 1 at the first edge after the call; returns index of first request edge
    task automatic run_to_req(input int maxc, input int sel_at, input int sel_val,
                              input int stb_at, input int stb_val, output int k);
        k = 0;
        while (k < maxc) begin
            @(posedge clk);
            #1;
            k++;
            if (timeout_req) break;
            if (k == sel_at) sel = 2'(sel_val);
            if (k == stb_at) strobe = 1'(stb_val);
        end
    endtask

    task automatic count_reqs(input int n, input bit toggle, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            if (timeout_req) c++;
            if (toggle && (i % 7 == 0)) strobe = ~strobe;
        end
    endtask

    initial begin
        int k;
        int c;
        // R1 reset state
        repeat (3) @(posedge clk);
        #1;
        check(timeout_req == 1'b0, "R1 during reset", int'(timeout_req), 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check(timeout_req == 1'b0, "R1 after reset", int'(timeout_req), 0);

        // vector table
        for (int v = 0; v < NV; v++) begin
            prepare(2'(VEC[v][0]), 1'b1);
            release_wd();
            run_to_req(200, (VEC[v][1] >= 0) ? 3 : -1, VEC[v][1], -1, 0, k);
            check(k == VEC[v][2], "R3/R4/R8 vector timing", k, VEC[v][2]);
            @(posedge clk);
            #1;
            check(timeout_req == 1'b0, "R9 single-cycle pulse", int'(timeout_req), 0);
        end

        // R2 hold while reset active, then count from new release
        prepare(2'b00, 1'b1);
        count_reqs(3 * LH, 1'b0, c);
        check(c == 0, "R2 no request in reset", c, 0);
        release_wd();
        run_to_req(10, -1, 0, -1, 0, k);
        @(negedge clk);
        rst_active = 1'b1;
        count_reqs(3 * LH, 1'b0, c);
        check(c == 0, "R2 reset mid-run", c, 0);
        release_wd();
        run_to_req(200, -1, 0, -1, 0, k);
        check(k == LG + 2, "R2 restart after release", k, LG + 2);

        // R5 falling strobe restarts
        prepare(2'b00, 1'b1);
        release_wd();
        run_to_req(200, -1, 0, 15, 0, k);
        check(k == 15 + LG + 4, "R5 fall restart", k, 15 + LG + 4);

        // R7 fall in the expiry cycle wins
        prepare(2'b00, 1'b1);
        release_wd();
        run_to_req(200, -1, 0, LG - 1, 0, k);
        check(k == 2 * LG + 3, "R7 fall at expiry wins", k, 2 * LG + 3);

        // R7 boundary: one cycle late does not save it
        prepare(2'b00, 1'b1);
        release_wd();
        run_to_req(200, -1, 0, LG, 0, k);
        check(k == LG + 2, "R7 late fall", k, LG + 2);

        // R6 strobe held low (fall happened during hold)
        prepare(2'b00, 1'b1);
        prepare(2'b00, 1'b0);
        release_wd();
        run_to_req(200, -1, 0, -1, 0, k);
        check(k == LG + 2, "R6 held low", k, LG + 2);

        // R6 rising transition is not service
        prepare(2'b00, 1'b0);
        release_wd();
        run_to_req(200, -1, 0, 10, 1, k);
        check(k == LG + 2, "R6 rising edge", k, LG + 2);

        // R9 quiet after request despite strobe activity, then re-arm
        count_reqs(3 * LH, 1'b1, c);
        check(c == 0, "R9 quiet after request", c, 0);
        prepare(2'b01, 1'b1);
        release_wd();
        run_to_req(200, -1, 0, -1, 0, k);
        check(k == LO + 2, "R9 re-arm after reset", k, LO + 2);

        // R10 tick gating
        prepare(2'b00, 1'b1);
        @(negedge clk);
        tick = 1'b0;
        rst_active = 1'b0;
        count_reqs(3 * LH, 1'b0, c);
        check(c == 0, "R10 no count without tick", c, 0);
        tick = 1'b1;
        run_to_req(200, -1, 0, -1, 0, k);
        check(k == LG + 1, "R10 count from first tick", k, LG + 1);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule